// File: doc/BRIEF.md
# Edge-Window Frequency Meter

This block measures how fast a slow external signal toggles. The signal has no fixed phase relation to the system clock, so the block never uses it as a clock. It is first passed through two flip-flops clocked by the system clock. A third flop holds the previous sample, and a rising edge is taken to be a current sample of 1 following a previous sample of 0. From the first rising edge after reset, the block counts system clock cycles. When sixteen further rising edges have arrived, it stores the count in its result register.

The stored count equals sixteen input periods expressed in system clock cycles. The closing edge of one window opens the next, so results follow one another with no gap. One cycle after each new result appears, a single-cycle ready strobe goes high. Downstream logic, such as a serial sender, can use this strobe to collect the value. A window that lasts longer than the counter can hold produces an all-ones result, which means the input is too slow to measure.

Correct results need an input whose high and low phases each last at least two system clock cycles. With a 50 MHz system clock, the intended inputs run far below that limit.

Top module: `freq_window_meter`

## Requirements
- R1: The raw input is sampled by two synchronising flip-flops, followed by one flip-flop that holds the previous sample. If the raw input goes high before clock edge k, a new result appears on `meas_o` at edge k+2, which is the third edge counted from k.
- R2: Each result is the number of system clock cycles from the rising edge that opens a window to the sixteenth rising edge after it. For a steady input with period P cycles, the result is 16·P.
- R3: The rising edge that closes a window also opens the next window, with the cycle count restarting at 1. Consecutive results from a steady input are therefore each equal to 16·P.
- R4: `ready_o` is high for exactly one clock cycle for each new result. It goes high in the cycle after `meas_o` takes the new value.
- R5: `meas_o` holds its value between results. Every change of `meas_o` outside reset is followed in the next cycle by a `ready_o` pulse.
- R6: If the cycle count reaches its all-ones maximum before a window closes, it stays at that maximum. The result latched for that window is then all ones.
- R7: Asserting `rst_n` low clears `meas_o` to 0 and `ready_o` to 0, and discards any window in progress. After reset is released, no result is produced until a window opens at the first detected rising edge and closes sixteen rising edges later.
- R8: The fastest supported input, with high and low phases of two cycles each, gives a result of 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sig_in | input | 1 | Raw external signal to be measured, asynchronous to `clk` |
| meas_o | output | CNT_W | Latest result: clock cycles in a sixteen-period window |
| ready_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The meter is driven with steady square and lopsided waves, from the two-cycle-phase limit up to periods of nearly two hundred cycles. These show that the result depends only on the total period and not on the duty cycle. Running several windows on one input tells a seamless window restart apart from off-by-one errors at the window boundary. A directed edge shows that a new result lands on the third clock edge after the input rises. A very slow input shows whether the counter holds at its maximum or wraps around. Resets applied mid-run and during a long idle period separate a correct window start, at the first edge after reset, from leftover state.

// File: rtl/fmeas_pkg.sv
package fmeas_pkg;
  // Window tracker: idle until the first rising edge, then running.
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;
endpackage

// File: rtl/fmeas_sync_edge.sv
module fmeas_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hist_q, hist_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    hist_d = sync_q[SYNC_STAGES-1];
    rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fmeas_window.sv
module fmeas_window
  import fmeas_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned WIN_EDGES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             close_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned      EDGE_W    = $clog2(WIN_EDGES);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(WIN_EDGES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  win_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d;
  logic [EDGE_W-1:0] edg_q, edg_d;
  logic              close;

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    edg_d   = edg_q;
    close   = 1'b0;
    case (state_q)
      WIN_IDLE: begin
        if (rise_i) begin
          state_d = WIN_RUN;
          cyc_d   = CNT_W'(1);
          edg_d   = '0;
        end
      end
      default: begin
        if (cyc_q != CNT_MAX) cyc_d = cyc_q + CNT_W'(1);
        if (rise_i) begin
          if (edg_q == EDGE_LAST) begin
            close = 1'b1;
            edg_d = '0;
            cyc_d = CNT_W'(1);
          end else begin
            edg_d = edg_q + EDGE_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cyc_q   <= '0;
      edg_q   <= '0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      edg_q   <= edg_d;
    end
  end

  assign close_o = close;
  assign count_o = cyc_q;

  // R6
  cyc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_RUN) |-> (cyc_q != '0));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |=> (cyc_q == CNT_W'(1)) && (edg_q == '0));
endmodule

// File: rtl/fmeas_result.sv
module fmeas_result #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             pend_q, pend_d;
  logic             ready_q, ready_d;

  always_comb begin
    meas_d  = load_i ? value_i : meas_q;
    pend_d  = load_i;
    ready_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q  <= '0;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      meas_q  <= meas_d;
      pend_q  <= pend_d;
      ready_q <= ready_d;
    end
  end

  assign meas_o  = meas_q;
  assign ready_o = ready_q;

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
endmodule

// File: rtl/freq_window_meter.sv
module freq_window_meter #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned WIN_EDGES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  output logic [CNT_W-1:0] meas_o,
  output logic             ready_o
);
  logic             rise;
  logic             close;
  logic [CNT_W-1:0] count;

  fmeas_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(sig_in), .rise_o(rise)
  );

  fmeas_window #(.CNT_W(CNT_W), .WIN_EDGES(WIN_EDGES)) win_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .close_o(close), .count_o(count)
  );

  fmeas_result #(.CNT_W(CNT_W)) res_i (
    .clk(clk), .rst_n(rst_n), .load_i(close), .value_i(count),
    .meas_o(meas_o), .ready_o(ready_o)
  );

  // R5
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_o) |=> ready_o);

  // R2
  ready_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (meas_o != '0));
endmodule

// File: tb/freq_window_meter_tb_top.sv
module freq_window_meter_tb_top;
  localparam int CW = 12;
  localparam int NV = 6;
  // each row: high cycles, low cycles, windows, expected result (16*(high+low))
  localparam int VEC [NV][4] = '{
    '{2,   2,  3, 64},
    '{3,   5,  2, 128},
    '{10,  10, 2, 320},
    '{7,   20, 2, 432},
    '{40,  25, 1, 1040},
    '{100, 90, 1, 3040}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sig;
  logic [CW-1:0] meas_o;
  logic          ready_o;

  int n_chk = 0, n_fail = 0, n_ready = 0, exp_val = 0;
  string cur_req = "R2";
  logic [CW-1:0] meas_p1 = '0;
  logic ready_p1 = 1'b0, rst_p1 = 1'b0, want_rdy = 1'b0;

  always #4 clk = ~clk;

  freq_window_meter #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .meas_o(meas_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rst_p1) begin
      if (want_rdy) chk(ready_o == 1'b1, "R5", int'(ready_o), 1);
      if (ready_o) begin
        n_ready++;
        chk(int'(meas_o) == exp_val, cur_req, int'(meas_o), exp_val);
        chk(meas_p1 == meas_o, "R4", int'(meas_p1), int'(meas_o));
        chk(!ready_p1, "R4", int'(ready_p1), 0);
      end
      want_rdy = (meas_o != meas_p1);
    end else begin
      want_rdy = 1'b0;
    end
    meas_p1  = meas_o;
    ready_p1 = ready_o;
    rst_p1   = rst_n;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sig   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic periods(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      sig = 1'b1;
      repeat (hi) @(negedge clk);
      sig = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic run_win(input int hi, input int lo, input int nwin,
                         input int expv, input string req);
    do_reset();
    exp_val = expv;
    cur_req = req;
    n_ready = 0;
    periods(hi, lo, 1 + 16 * nwin);
    repeat (6) @(negedge clk);
    chk(n_ready == nwin, req, n_ready, nwin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R7: reset state and idle behaviour
    rst_n = 1'b0;
    sig   = 1'b0;
    repeat (3) @(negedge clk);
    chk(meas_o == '0, "R7", int'(meas_o), 0);
    chk(ready_o == 1'b0, "R7", int'(ready_o), 0);
    rst_n   = 1'b1;
    n_ready = 0;
    repeat (200) @(negedge clk);
    chk(n_ready == 0, "R7", n_ready, 0);
    chk(meas_o == '0, "R7", int'(meas_o), 0);

    // Table walk: R2 values, R3 back-to-back windows, R8 fastest input
    for (int v = 0; v < NV; v++) begin
      run_win(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
              (v == 0) ? "R8" : (VEC[v][2] > 1 ? "R3" : "R2"));
    end

    // R1: latency from the closing raw edge to the new result
    do_reset();
    exp_val = 320;
    cur_req = "R1";
    n_ready = 0;
    periods(10, 10, 16);
    sig = 1'b1;
    repeat (2) @(negedge clk);
    chk(meas_o == '0, "R1", int'(meas_o), 0);
    @(negedge clk);
    chk(int'(meas_o) == 320, "R1", int'(meas_o), 320);
    chk(ready_o == 1'b0, "R4", int'(ready_o), 0);
    @(negedge clk);
    chk(ready_o == 1'b1, "R4", int'(ready_o), 1);
    repeat (6) @(negedge clk);
    sig = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_ready == 1, "R4", n_ready, 1);

    // R6: input too slow, counter holds at all ones
    run_win(150, 150, 1, (1 << CW) - 1, "R6");

    // R7: reset in mid-run, then a clean window from the first edge
    do_reset();
    exp_val = 320;
    cur_req = "R7";
    periods(10, 10, 22);
    chk(int'(meas_o) == 320, "R7", int'(meas_o), 320);
    rst_n = 1'b0;
    @(negedge clk);
    chk(meas_o == '0, "R7", int'(meas_o), 0);
    chk(ready_o == 1'b0, "R7", int'(ready_o), 0);
    rst_n   = 1'b1;
    exp_val = 192;
    n_ready = 0;
    periods(6, 6, 17);
    repeat (6) @(negedge clk);
    chk(n_ready == 1, "R7", n_ready, 1);
    chk(int'(meas_o) == 192, "R7", int'(meas_o), 192);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule